// File: doc/BRIEF.md
# Serial Channel Command Decoder

This block sits behind the command register of one serial channel. Each byte written there is decoded in the cycle it arrives. The decode turns the receiver and the transmitter on or off and produces one-cycle strobes. Those strobes let the status register, the interrupt status register and the mode-register pointer of the channel set or clear their own bits. The serializers and the flag storage live outside this block. It hands them strobes and two enable levels.

The block also owns the break condition on the transmit line. When a break is requested, the block waits until the transmitter has nothing left to send and a bit-time tick arrives. It then forces the line low. When the break is stopped, the line stays low up to the next tick. It then goes high and stays high for one more bit time, and during that time the serializer is told to hold off its next character. A parameter gives the channel number, which places the channel's two bits in the interrupt status vector.

Top module: `ser_cmd_decoder`

## Requirements
- R1: With `cmd_wr` high, command bit 0 turns the receiver on and bit 2 turns the transmitter on. `rx_en` and `tx_en` follow at the clock edge that takes the write. Bit 7 and cycles with `cmd_wr` low change nothing.
- R2: Bit 1 turns the receiver off and bit 3 turns the transmitter off. When the on and off bits for one direction are both set, that direction ends up off.
- R3: Turning the transmitter on pulses `txrdy_set`, `txemt_set` and `isr_set[4*CH_IDX]` for the one cycle after the write.
- R4: Turning the transmitter off pulses `txrdy_clr` and `txemt_clr` for one cycle. Turning the receiver off pulses `rxrdy_clr` for one cycle.
- R5: Action code 1 in bits 6:4 pulses `mptr_rst`, which points the mode pointer back at the first mode register.
- R6: Action code 2 resets the receiver. It turns the receiver off, pulses `rxrdy_clr` and `rx_flush`, and wins over bit 0 in the same byte.
- R7: Action code 3 resets the transmitter. It turns the transmitter off, pulses `txrdy_clr`, `txemt_clr` and `tx_flush`, and wins over bit 2 in the same byte.
- R8: Action code 4 pulses `err_clr`, which clears the break, framing, parity and overrun error bits. Action code 5 pulses `isr_clr[2+4*CH_IDX]`, the channel's break-change interrupt bit.
- R9: Action code 6 arms a break only if the transmitter is on once the same byte's on/off bits have been applied. Otherwise the line stays high and no break follows.
- R10: An armed break drives `tx_line` low at the first clock edge at which `bit_tick` is high and both `tx_busy` and `thr_full` are low.
- R11: Action code 7 during a break keeps `tx_line` low until the next `bit_tick`. The line then goes high, and `tx_hold` stays high until one further `bit_tick`. `tx_hold` is also high throughout the break.
- R12: Action code 7 while a break is only armed cancels it. Turning the transmitter off (bit 3 or code 3) at any point in the break sequence returns `tx_line` high and `tx_hold` low at once.
- R13: After reset, both directions are off, no strobe is active, `tx_line` is high and `tx_hold` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_wr | input | 1 | Write strobe for the command byte |
| cmd_byte | input | 8 | Command byte |
| bit_tick | input | 1 | One-cycle pulse per transmit bit time |
| tx_busy | input | 1 | Transmit shifter is sending a character |
| thr_full | input | 1 | Transmit holding register holds a character |
| rx_en | output | 1 | Receiver enable level |
| tx_en | output | 1 | Transmitter enable level |
| txrdy_set | output | 1 | Set transmitter-ready |
| txrdy_clr | output | 1 | Clear transmitter-ready |
| txemt_set | output | 1 | Set transmitter-empty |
| txemt_clr | output | 1 | Clear transmitter-empty |
| rxrdy_clr | output | 1 | Clear receiver-ready |
| rx_flush | output | 1 | Flush the receive buffer |
| tx_flush | output | 1 | Flush the transmit buffer |
| err_clr | output | 1 | Clear the break, framing, parity and overrun error bits |
| mptr_rst | output | 1 | Point the mode pointer back at the first mode register |
| isr_set | output | 8 | Per-bit set strobes for the interrupt status vector |
| isr_clr | output | 8 | Per-bit clear strobes for the interrupt status vector |
| tx_line | output | 1 | Transmit line level after break forcing (0 = held low) |
| tx_hold | output | 1 | Serializer must not start a character |

## Verification
The bench goes after bytes that set both the on and off bit of one direction. A decoder with the wrong priority would leave that direction running. It also sends reset codes together with an enable bit; a wrong decoder would re-enable a receiver or transmitter that should have been reset. Break requests are sent while the shifter is busy or the holding register is full, and while the transmitter is off. A faulty sequencer would cut a character short or start a break that should be refused. Stop, cancel and disable are sent at each break stage, because a wrong guard period would let the next character start straight after the line rises. The channel number is overridden so that a misplaced interrupt bit shows up in the wrong position.

// File: rtl/cmd_pkg.sv
// Shared types for the serial channel command decoder.
// Assumes an 8-bit command byte and an 8-bit interrupt status vector.
package cmd_pkg;

    localparam int ISR_W = 8;

    // Action codes carried in command bits 6:4
    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_MPTR   = 3'd1,
        ACT_RXRST  = 3'd2,
        ACT_TXRST  = 3'd3,
        ACT_ERRCLR = 3'd4,
        ACT_BRKCLR = 3'd5,
        ACT_BRKON  = 3'd6,
        ACT_BRKOFF = 3'd7
    } cmd_act_e;

    // Break sequencer states
    typedef enum logic [2:0] {
        BK_IDLE  = 3'd0,
        BK_PEND  = 3'd1,
        BK_LOW   = 3'd2,
        BK_STOP  = 3'd3,
        BK_GUARD = 3'd4
    } brk_st_e;

endpackage

// File: rtl/cmd_field_dec.sv
// Combinational decode of one command byte into direction intents and an action.
// Assumes the caller gates nothing: every output is already qualified by wr.
// The off intent of a direction already includes that direction's reset code,
// so an off request or a reset always beats an on request.
module cmd_field_dec
    import cmd_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic             wr,
    input  logic [CMD_W-1:0] cmd,
    output logic             rx_on,
    output logic             rx_off,
    output logic             tx_on,
    output logic             tx_off,
    output cmd_act_e         act
);

    // Decode the action field, qualified by the write strobe
    always_comb begin
        act = wr ? cmd_act_e'(cmd[6:4]) : ACT_NONE;
    end

    // Resolve on/off per direction with off winning
    always_comb begin
        rx_off = wr && (cmd[1] || act == ACT_RXRST);
        tx_off = wr && (cmd[3] || act == ACT_TXRST);
        rx_on  = wr && cmd[0] && !rx_off;
        tx_on  = wr && cmd[2] && !tx_off;
    end

endmodule

// File: rtl/cmd_flag_ctl.sv
// Holds the enable levels and registers the one-cycle flag strobes.
// Assumes decoded intents from cmd_field_dec; the strobes are valid in the
// cycle after the write, and the enables change at the write edge.
module cmd_flag_ctl
    import cmd_pkg::*;
#(
    parameter int CH_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_on,
    input  logic             rx_off,
    input  logic             tx_on,
    input  logic             tx_off,
    input  cmd_act_e         act,
    output logic             tx_en_nxt,
    output logic             rx_en,
    output logic             tx_en,
    output logic             txrdy_set,
    output logic             txrdy_clr,
    output logic             txemt_set,
    output logic             txemt_clr,
    output logic             rxrdy_clr,
    output logic             rx_flush,
    output logic             tx_flush,
    output logic             err_clr,
    output logic             mptr_rst,
    output logic [ISR_W-1:0] isr_set,
    output logic [ISR_W-1:0] isr_clr
);

    localparam int TXI_BIT = 4 * CH_IDX;
    localparam int BCI_BIT = 2 + 4 * CH_IDX;

    logic             rx_en_nxt;
    logic [ISR_W-1:0] set_vec;
    logic [ISR_W-1:0] clr_vec;

    // Next enable levels: off first, then on, else hold
    always_comb begin
        rx_en_nxt = rx_off ? 1'b0 : (rx_on ? 1'b1 : rx_en);
        tx_en_nxt = tx_off ? 1'b0 : (tx_on ? 1'b1 : tx_en);
    end

    // One strobe per interrupt status bit, chosen by the channel number
    for (genvar g = 0; g < ISR_W; g++) begin : g_isr
        assign set_vec[g] = tx_on && (g == TXI_BIT);
        assign clr_vec[g] = (act == ACT_BRKCLR) && (g == BCI_BIT);
    end

    // Register enables and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en     <= 1'b0;
            tx_en     <= 1'b0;
            txrdy_set <= 1'b0;
            txrdy_clr <= 1'b0;
            txemt_set <= 1'b0;
            txemt_clr <= 1'b0;
            rxrdy_clr <= 1'b0;
            rx_flush  <= 1'b0;
            tx_flush  <= 1'b0;
            err_clr   <= 1'b0;
            mptr_rst  <= 1'b0;
            isr_set   <= '0;
            isr_clr   <= '0;
        end else begin
            rx_en     <= rx_en_nxt;
            tx_en     <= tx_en_nxt;
            txrdy_set <= tx_on;
            txemt_set <= tx_on;
            txrdy_clr <= tx_off;
            txemt_clr <= tx_off;
            rxrdy_clr <= rx_off;
            rx_flush  <= (act == ACT_RXRST);
            tx_flush  <= (act == ACT_TXRST);
            err_clr   <= (act == ACT_ERRCLR);
            mptr_rst  <= (act == ACT_MPTR);
            isr_set   <= set_vec;
            isr_clr   <= clr_vec;
        end
    end

    // R4: ready flag is never set and cleared in the same cycle
    assert_rdy_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(txrdy_set && txrdy_clr));

    // R3: a transmit-ready set strobe comes with the enabled transmitter
    assert_set_with_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        txrdy_set |-> tx_en);

endmodule

// File: rtl/brk_seq.sv
// Break sequencer for the transmit line.
// Assumes bit_tick is a one-cycle pulse per bit time. tx_busy and thr_full
// are levels from the serializer. The line is forced low in LOW and STOP.
// tx_hold is high from LOW through the guard bit.
module brk_seq
    import cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic stop_req,
    input  logic tx_off,
    input  logic tx_en_nxt,
    input  logic bit_tick,
    input  logic tx_busy,
    input  logic thr_full,
    output logic tx_line,
    output logic tx_hold
);

    brk_st_e st;
    brk_st_e st_nxt;
    logic    tx_quiet;

    assign tx_quiet = !tx_busy && !thr_full;

    // Next-state selection; turning the transmitter off cancels any stage
    always_comb begin
        st_nxt = st;
        if (tx_off) begin
            st_nxt = BK_IDLE;
        end else begin
            unique case (st)
                BK_IDLE:  if (start_req && tx_en_nxt) st_nxt = BK_PEND;
                BK_PEND:  if (stop_req) st_nxt = BK_IDLE;
                          else if (bit_tick && tx_quiet) st_nxt = BK_LOW;
                BK_LOW:   if (stop_req) st_nxt = BK_STOP;
                BK_STOP:  if (bit_tick) st_nxt = BK_GUARD;
                BK_GUARD: if (bit_tick) st_nxt = BK_IDLE;
                default:  st_nxt = BK_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= BK_IDLE;
        else        st <= st_nxt;
    end

    // Output decode from the state
    always_comb begin
        tx_line = !(st == BK_LOW || st == BK_STOP);
        tx_hold = (st == BK_LOW || st == BK_STOP || st == BK_GUARD);
    end

    // R10: the line only drops on a tick with the transmitter quiet
    assert_brk_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_line) |-> $past(bit_tick && tx_quiet));

    // R11: the line rises into a held guard bit unless cancelled
    assert_guard_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_line) |-> (tx_hold || $past(tx_off)));

    // R9: a break request with the transmitter off is refused
    assert_start_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_IDLE && start_req && !tx_en_nxt) |=> (st == BK_IDLE));

    // R12: turning the transmitter off releases the line
    assert_cancel_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_off |=> (tx_line && !tx_hold));

endmodule

// File: rtl/ser_cmd_decoder.sv
// Serial channel command decoder: decodes command bytes into enable levels,
// flag strobes and break control of the transmit line.
// Assumes one channel per instance; CH_IDX places its interrupt status bits.
module ser_cmd_decoder
    import cmd_pkg::*;
#(
    parameter int CH_IDX = 0,
    parameter int CMD_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_byte,
    input  logic             bit_tick,
    input  logic             tx_busy,
    input  logic             thr_full,
    output logic             rx_en,
    output logic             tx_en,
    output logic             txrdy_set,
    output logic             txrdy_clr,
    output logic             txemt_set,
    output logic             txemt_clr,
    output logic             rxrdy_clr,
    output logic             rx_flush,
    output logic             tx_flush,
    output logic             err_clr,
    output logic             mptr_rst,
    output logic [ISR_W-1:0] isr_set,
    output logic [ISR_W-1:0] isr_clr,
    output logic             tx_line,
    output logic             tx_hold
);

    logic     rx_on, rx_off, tx_on, tx_off, tx_en_nxt;
    cmd_act_e act;

    // Byte decode
    cmd_field_dec #(.CMD_W(CMD_W)) i_dec (
        .wr     (cmd_wr),
        .cmd    (cmd_byte),
        .rx_on  (rx_on),
        .rx_off (rx_off),
        .tx_on  (tx_on),
        .tx_off (tx_off),
        .act    (act)
    );

    // Enables and strobes
    cmd_flag_ctl #(.CH_IDX(CH_IDX)) i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_on     (rx_on),
        .rx_off    (rx_off),
        .tx_on     (tx_on),
        .tx_off    (tx_off),
        .act       (act),
        .tx_en_nxt (tx_en_nxt),
        .rx_en     (rx_en),
        .tx_en     (tx_en),
        .txrdy_set (txrdy_set),
        .txrdy_clr (txrdy_clr),
        .txemt_set (txemt_set),
        .txemt_clr (txemt_clr),
        .rxrdy_clr (rxrdy_clr),
        .rx_flush  (rx_flush),
        .tx_flush  (tx_flush),
        .err_clr   (err_clr),
        .mptr_rst  (mptr_rst),
        .isr_set   (isr_set),
        .isr_clr   (isr_clr)
    );

    // Break control of the transmit line
    brk_seq i_brk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (act == ACT_BRKON),
        .stop_req  (act == ACT_BRKOFF),
        .tx_off    (tx_off),
        .tx_en_nxt (tx_en_nxt),
        .bit_tick  (bit_tick),
        .tx_busy   (tx_busy),
        .thr_full  (thr_full),
        .tx_line   (tx_line),
        .tx_hold   (tx_hold)
    );

    // R2: transmitter off bit leaves the transmitter off
    assert_tx_off_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_byte[3]) |=> !tx_en);

    // R2: receiver off bit leaves the receiver off
    assert_rx_off_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_byte[1]) |=> !rx_en);

    // R6: receiver reset disables and flushes
    assert_rx_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_byte[6:4] == 3'd2) |=> (!rx_en && rx_flush && rxrdy_clr));

    // R7: transmitter reset disables and flushes
    assert_tx_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_byte[6:4] == 3'd3) |=> (!tx_en && tx_flush && txemt_clr));

endmodule

// File: tb/test_ser_cmd_decoder.sv
module test_ser_cmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int CH         = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       bit_tick = 1'b0;
    logic       tx_busy = 1'b0;
    logic       thr_full = 1'b0;
    logic       rx_en, tx_en, txrdy_set, txrdy_clr, txemt_set, txemt_clr;
    logic       rxrdy_clr, rx_flush, tx_flush, err_clr, mptr_rst;
    logic [7:0] isr_set, isr_clr;
    logic       tx_line, tx_hold;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Model state
    bit       m_rx, m_tx;
    int       m_st;        // 0 idle 1 pend 2 low 3 stop 4 guard
    bit [7:0] m_isr_set, m_isr_clr;
    bit       m_trs, m_trc, m_rrc, m_rfl, m_tfl, m_ecl, m_mpt;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_cmd_decoder #(.CH_IDX(CH)) i_ser_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
        .bit_tick(bit_tick), .tx_busy(tx_busy), .thr_full(thr_full),
        .rx_en(rx_en), .tx_en(tx_en), .txrdy_set(txrdy_set), .txrdy_clr(txrdy_clr),
        .txemt_set(txemt_set), .txemt_clr(txemt_clr), .rxrdy_clr(rxrdy_clr),
        .rx_flush(rx_flush), .tx_flush(tx_flush), .err_clr(err_clr),
        .mptr_rst(mptr_rst), .isr_set(isr_set), .isr_clr(isr_clr),
        .tx_line(tx_line), .tx_hold(tx_hold)
    );

    task automatic chk(input string req, input string nm, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
        end
    endtask

    function automatic bit exp_line(input int st);
        return !(st == 2 || st == 3);
    endfunction

    function automatic bit exp_hold(input int st);
        return (st == 2 || st == 3 || st == 4);
    endfunction

    task automatic model_reset();
        m_rx = 0; m_tx = 0; m_st = 0;
        m_isr_set = '0; m_isr_clr = '0;
        {m_trs, m_trc, m_rrc, m_rfl, m_tfl, m_ecl, m_mpt} = '0;
    endtask

    // Model of one clock edge, from the requirements
    task automatic model_step(input bit wr, input bit [7:0] b, input bit tk,
                              input bit bsy, input bit ful);
        int  code;
        bit  rxoff, rxon, txoff, txon, ntx;
        code  = wr ? int'(b[6:4]) : 0;
        rxoff = wr && (b[1] || code == 2);
        txoff = wr && (b[3] || code == 3);
        rxon  = wr && b[0] && !rxoff;
        txon  = wr && b[2] && !txoff;
        ntx   = txoff ? 1'b0 : (txon ? 1'b1 : m_tx);
        if (txoff) m_st = 0;
        else begin
            case (m_st)
                0: if (code == 6 && ntx) m_st = 1;
                1: if (code == 7) m_st = 0; else if (tk && !bsy && !ful) m_st = 2;
                2: if (code == 7) m_st = 3;
                3: if (tk) m_st = 4;
                4: if (tk) m_st = 0;
                default: m_st = 0;
            endcase
        end
        m_rx  = rxoff ? 1'b0 : (rxon ? 1'b1 : m_rx);
        m_tx  = ntx;
        m_trs = txon;
        m_trc = txoff;
        m_rrc = rxoff;
        m_rfl = (code == 2);
        m_tfl = (code == 3);
        m_ecl = (code == 4);
        m_mpt = (code == 1);
        m_isr_set = '0; m_isr_clr = '0;
        m_isr_set[4*CH]   = txon;
        m_isr_clr[2+4*CH] = (code == 5);
    endtask

    task automatic compare_all();
        chk("R1", "rx_en", rx_en, m_rx);
        chk("R1", "tx_en", tx_en, m_tx);
        chk("R3", "txrdy_set", {txrdy_set, txemt_set}, {m_trs, m_trs});
        chk("R3", "isr_set", isr_set, m_isr_set);
        chk("R4", "tx_clr", {txrdy_clr, txemt_clr}, {m_trc, m_trc});
        chk("R4", "rxrdy_clr", rxrdy_clr, m_rrc);
        chk("R5", "mptr_rst", mptr_rst, m_mpt);
        chk("R6", "rx_flush", rx_flush, m_rfl);
        chk("R7", "tx_flush", tx_flush, m_tfl);
        chk("R8", "err_clr", err_clr, m_ecl);
        chk("R8", "isr_clr", isr_clr, m_isr_clr);
        chk("R10", "tx_line", tx_line, exp_line(m_st));
        chk("R11", "tx_hold", tx_hold, exp_hold(m_st));
    endtask

    // Drive one cycle from a negedge, update the model at the edge, compare at next negedge
    task automatic cyc(input bit wr, input bit [7:0] b, input bit tk,
                       input bit bsy, input bit ful);
        cmd_wr = wr; cmd_byte = b; bit_tick = tk; tx_busy = bsy; thr_full = ful;
        @(posedge clk);
        model_step(wr, b, tk, bsy, ful);
        @(negedge clk);
        cmd_wr = 0; bit_tick = 0;
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed;
        seed = 32'h5eed_c0de;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        // R13: reset state
        chk("R13", "rst_en", {rx_en, tx_en}, 0);
        chk("R13", "rst_line", {tx_line, tx_hold}, 2'b10);
        chk("R13", "rst_strobes", {isr_set, isr_clr, txrdy_set, rxrdy_clr}, 0);
        rst_n = 1;
        cyc(0, 8'hFF, 0, 0, 0);
        chk("R1", "no_wr_no_change", {rx_en, tx_en}, 0);

        // R1: both on, bit 7 ignored
        cyc(1, 8'h85, 0, 0, 0);
        chk("R1", "both_on", {rx_en, tx_en}, 2'b11);
        // R2: on and off together -> off
        cyc(1, 8'h0F, 0, 0, 0);
        chk("R2", "off_wins", {rx_en, tx_en}, 2'b00);
        // R6: receiver reset with enable bit
        cyc(1, 8'h21, 0, 0, 0);
        chk("R6", "rx_reset_beats_on", {rx_en, rx_flush}, 2'b01);
        // R7: transmitter reset with enable bit
        cyc(1, 8'h34, 0, 0, 0);
        chk("R7", "tx_reset_beats_on", {tx_en, tx_flush}, 2'b01);
        cyc(1, 8'h50, 0, 0, 0);
        chk("R8", "brk_change_clr_pos", isr_clr, 8'h40);
        cyc(1, 8'h10, 0, 0, 0);
        cyc(1, 8'h40, 0, 0, 0);

        // R9: break refused with transmitter off
        cyc(1, 8'h60, 0, 0, 0);
        cyc(0, 8'h00, 1, 0, 0);
        chk("R9", "refused_line", tx_line, 1);
        // R9: accepted when the same byte turns the transmitter on
        cyc(1, 8'h64, 0, 0, 0);
        chk("R3", "isr_set_pos", isr_set, 8'h10);
        // R10: wait while busy / full
        cyc(0, 8'h00, 1, 1, 0);
        chk("R10", "busy_wait", tx_line, 1);
        cyc(0, 8'h00, 1, 0, 1);
        chk("R10", "full_wait", tx_line, 1);
        cyc(0, 8'h00, 0, 0, 0);
        chk("R10", "no_tick_wait", tx_line, 1);
        cyc(0, 8'h00, 1, 0, 0);
        chk("R10", "break_low", {tx_line, tx_hold}, 2'b01);
        // R11: stop then guard bit
        cyc(1, 8'h70, 1, 0, 0);
        chk("R11", "stop_still_low", tx_line, 0);
        cyc(0, 8'h00, 1, 0, 0);
        chk("R11", "guard_high_hold", {tx_line, tx_hold}, 2'b11);
        cyc(0, 8'h00, 1, 0, 0);
        chk("R11", "guard_done", {tx_line, tx_hold}, 2'b10);
        // R12: cancel while armed
        cyc(1, 8'h60, 0, 1, 0);
        cyc(1, 8'h70, 0, 0, 0);
        cyc(0, 8'h00, 1, 0, 0);
        chk("R12", "cancel_armed", {tx_line, tx_hold}, 2'b10);
        // R12: transmitter off during break
        cyc(1, 8'h60, 1, 0, 0);
        cyc(0, 8'h00, 1, 0, 0);
        chk("R12", "low_before_off", tx_line, 0);
        cyc(1, 8'h08, 0, 0, 0);
        chk("R12", "off_releases", {tx_line, tx_hold}, 2'b10);

        // Random phase, weighted toward command writes and break codes
        for (int i = 0; i < 4000; i++) begin
            bit [7:0] b;
            b = 8'($urandom);
            if (($urandom % 3) == 0) b[6:5] = 2'b11;
            cyc(($urandom % 3) == 0, b, ($urandom % 3) == 0,
                ($urandom % 4) == 0, ($urandom % 5) == 0);
        end
        finish_run();
    end

endmodule